// File: doc/BRIEF.md
# Command Register with Parameter Word Collector

This block sits behind a small memory-mapped register window and turns a stream of 32-bit register writes into discrete command executions. Software writes a command code to the command register and then pushes the command's parameter words, one per write, into the data register. The block keeps the words in a small buffer. When enough bytes have arrived for the selected command, it executes the command. No separate start bit exists: the amount of data received is the trigger. A command that takes no parameters executes in the same cycle as its code write.

A few commands are settled locally: unrecognised codes, the configuration query, and the two commands whose parameter size is undefined. Each of these returns failure. The ring-setup command checks its two page counts locally. Every other command, and a ring setup that passes the check, is handed to the consumer. The block raises a one-cycle execute strobe together with the command code and the collected words, and takes the consumer's result code in that same cycle. The result is latched into a status register that software reads back.

Top module: `cmd_collector`

## Requirements
- R1: After reset, the status register at byte offset 0x8 reads 0x00000000 (success), no command is pending and the execute strobe is low.
- R2: A code write (offset 0x0) whose full 32-bit value is 0 or 10 or greater selects the unknown entry. It completes at once with status 0xFFFFFFFF (failure) and raises no execute strobe.
- R3: A code write that selects a command needing one or more parameter words sets the status to 0x00000001 (more data needed).
- R4: Each write to the data register (offset 0x4) stores one word. The command completes on exactly the write that brings the word count times 4 to at least the command's byte size. Before that write the status stays 0x00000001 and no strobe is raised. Sizes in words: code 1 takes 6, code 4 takes 4, codes 5, 7 and 9 take 2, codes 2, 3, 6 and 8 take 0.
- R5: Handed-over commands (codes 5, 6, 7, 8, 9, and code 4 when its check passes) raise the execute strobe, with the code on the command output, for exactly the completing write. The status then takes the value on the result input in that cycle. Codes 6 and 8 do so on the code write itself.
- R6: Code 1 completes after 6 words. Codes 2 and 3 complete on the code write. All three give status 0xFFFFFFFF and raise no strobe.
- R7: For code 4, word 0 is the request page count and word 1 is the completion page count. If either count is 0 or greater than MAX_PAGES (default 32), the command fails with 0xFFFFFFFF and raises no strobe. Otherwise it is handed over as in R5.
- R8: While the strobe is high, the argument output holds parameter word k at bits [32k+31:32k], in arrival order, and includes the word written in that cycle.
- R9: A data write while no command is pending is treated as the unknown command. It completes with status 0xFFFFFFFF and raises no strobe.
- R10: A code write during collection discards the words already received and starts counting again from zero for the new code.
- R11: A read returns data one cycle later. Offset 0x8 returns the last latched status and other offsets return 0. Reads change no state.
- R12: The execute strobe is high only in a cycle with a register write, and at most once per write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_wr_i | input | 1 | Register write enable |
| bus_rd_i | input | 1 | Register read enable |
| bus_addr_i | input | ADDR_W | Byte offset of the access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, one cycle after the read |
| exec_o | output | 1 | Execute strobe for a handed-over command |
| exec_cmd_o | output | 4 | Code of the command being executed |
| exec_args_o | output | ARG_WORDS*32 | Collected parameter words |
| exec_result_i | input | 32 | Consumer's result code, sampled while exec_o is high |

## Verification
On every cycle the assertions check four things: the strobe appears only on writes, unrecognised codes never execute, the word counter stays within the buffer and is zero whenever nothing is pending, and the status changes only on writes. Only the bench scenarios can show the per-command completion counts, the page-count boundaries of the ring-setup check, the order of the words on the argument output, the restart on a new code, and that the consumer's result ends up in the status register.

// File: rtl/cmd_collector_pkg.sv
package cmd_collector_pkg;

  typedef enum logic [3:0] {
    CMD_NONE     = 4'd0,
    CMD_CFG      = 4'd1,
    CMD_ISSUE    = 4'd2,
    CMD_UNPLUG   = 4'd3,
    CMD_RINGS    = 4'd4,
    CMD_DEV_RST  = 4'd5,
    CMD_BUS_RST  = 4'd6,
    CMD_MSG_RING = 4'd7,
    CMD_ADP_RST  = 4'd8,
    CMD_ABORT    = 4'd9,
    CMD_END      = 4'd10
  } cmd_e;

  localparam logic [31:0] ST_OK   = 32'h0000_0000;
  localparam logic [31:0] ST_MORE = 32'h0000_0001;
  localparam logic [31:0] ST_FAIL = 32'hFFFF_FFFF;

  localparam logic [7:0] CFG_WORDS  = 8'd6;
  localparam logic [7:0] RING_WORDS = 8'd4;
  localparam logic [7:0] PAIR_WORDS = 8'd2;

  // parameter words a command needs before it completes
  function automatic logic [7:0] need_words(cmd_e c);
    case (c)
      CMD_CFG:                          need_words = CFG_WORDS;
      CMD_RINGS:                        need_words = RING_WORDS;
      CMD_DEV_RST, CMD_MSG_RING,
      CMD_ABORT:                        need_words = PAIR_WORDS;
      default:                          need_words = 8'd0;
    endcase
  endfunction

endpackage

// File: rtl/cmd_code_decode.sv
module cmd_code_decode
  import cmd_collector_pkg::*;
(
  input  logic [31:0] code_i,
  output cmd_e        cmd_o
);
  // full-width compare: high bits set never alias a valid code
  always_comb begin
    if (code_i > 32'd0 && code_i < 32'(CMD_END)) cmd_o = cmd_e'(code_i[3:0]);
    else                                          cmd_o = CMD_NONE;
  end
endmodule

// File: rtl/cmd_word_buffer.sv
module cmd_word_buffer #(
  parameter int unsigned ARG_WORDS = 6,
  localparam int unsigned CNT_W    = $clog2(ARG_WORDS + 1)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clear_i,
  input  logic                      push_i,
  input  logic [31:0]               word_i,
  output logic [CNT_W-1:0]          cnt_o,
  output logic [ARG_WORDS*32-1:0]   args_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             room;

  assign room  = cnt_q < CNT_W'(ARG_WORDS);
  assign cnt_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (clear_i)         cnt_q <= '0;
    else if (push_i && room)  cnt_q <= cnt_q + 1'b1;
  end

  for (genvar k = 0; k < ARG_WORDS; k++) begin : g_slot
    logic [31:0] slot_q;
    logic        hit;
    assign hit = push_i && (cnt_q == CNT_W'(k));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)  slot_q <= '0;
      else if (hit) slot_q <= word_i;
    end
    // forward the word being written so the completing cycle sees it
    assign args_o[k*32 +: 32] = hit ? word_i : slot_q;
  end
endmodule

// File: rtl/cmd_verdict.sv
module cmd_verdict
  import cmd_collector_pkg::*;
#(
  parameter int unsigned ARG_WORDS = 6,
  parameter int unsigned MAX_PAGES = 32
) (
  input  cmd_e                     cmd_i,
  input  logic [ARG_WORDS*32-1:0]  args_i,
  input  logic [31:0]              ext_result_i,
  output logic [31:0]              result_o,
  output logic                     ext_o
);
  logic [31:0] req_pages, cmp_pages;
  logic        pages_ok;

  assign req_pages = args_i[31:0];
  assign cmp_pages = args_i[63:32];
  assign pages_ok  = (req_pages != 32'd0) && (req_pages <= 32'(MAX_PAGES)) &&
                     (cmp_pages != 32'd0) && (cmp_pages <= 32'(MAX_PAGES));

  always_comb begin
    ext_o    = 1'b0;
    result_o = ST_FAIL;
    case (cmd_i)
      CMD_RINGS: begin
        ext_o    = pages_ok;
        result_o = pages_ok ? ext_result_i : ST_FAIL;
      end
      CMD_DEV_RST, CMD_BUS_RST, CMD_MSG_RING, CMD_ADP_RST, CMD_ABORT: begin
        ext_o    = 1'b1;
        result_o = ext_result_i;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/cmd_collector.sv
module cmd_collector
  import cmd_collector_pkg::*;
#(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned ARG_WORDS = 6,
  parameter int unsigned MAX_PAGES = 32,
  localparam int unsigned CNT_W    = $clog2(ARG_WORDS + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     bus_wr_i,
  input  logic                     bus_rd_i,
  input  logic [ADDR_W-1:0]        bus_addr_i,
  input  logic [31:0]              bus_wdata_i,
  output logic [31:0]              bus_rdata_o,
  output logic                     exec_o,
  output logic [3:0]               exec_cmd_o,
  output logic [ARG_WORDS*32-1:0]  exec_args_o,
  input  logic [31:0]              exec_result_i
);
  localparam logic [ADDR_W-1:0] OFF_CMD    = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] OFF_DATA   = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] OFF_STATUS = ADDR_W'(8);

  cmd_e             cur_q, dec_cmd, eval_cmd;
  logic [31:0]      status_q, rdata_q, result;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       have_words;
  logic             wr_cmd, wr_dat, done, ext;

  assign wr_cmd = bus_wr_i && (bus_addr_i == OFF_CMD);
  assign wr_dat = bus_wr_i && (bus_addr_i == OFF_DATA);

  cmd_code_decode u_dec (
    .code_i (bus_wdata_i),
    .cmd_o  (dec_cmd)
  );

  cmd_word_buffer #(.ARG_WORDS(ARG_WORDS)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (wr_cmd || done),
    .push_i  (wr_dat),
    .word_i  (bus_wdata_i),
    .cnt_o   (cnt_q),
    .args_o  (exec_args_o)
  );

  assign eval_cmd   = wr_cmd ? dec_cmd : cur_q;
  assign have_words = wr_cmd ? 8'd0 : (8'(cnt_q) + 8'(wr_dat));
  assign done       = (wr_cmd || wr_dat) && (have_words >= need_words(eval_cmd));

  cmd_verdict #(.ARG_WORDS(ARG_WORDS), .MAX_PAGES(MAX_PAGES)) u_verdict (
    .cmd_i        (eval_cmd),
    .args_i       (exec_args_o),
    .ext_result_i (exec_result_i),
    .result_o     (result),
    .ext_o        (ext)
  );

  assign exec_o     = done && ext;
  assign exec_cmd_o = eval_cmd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q    <= CMD_NONE;
      status_q <= ST_OK;
    end else if (done) begin
      cur_q    <= CMD_NONE;
      status_q <= result;
    end else if (wr_cmd) begin
      cur_q    <= dec_cmd;
      status_q <= ST_MORE;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rdata_q <= '0;
    else if (bus_rd_i) rdata_q <= (bus_addr_i == OFF_STATUS) ? status_q : 32'd0;
  end
  assign bus_rdata_o = rdata_q;
endmodule

// File: rtl/cmd_collector_chk.sv
module cmd_collector_chk #(
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned ARG_WORDS = 6,
  localparam int unsigned CNT_W    = $clog2(ARG_WORDS + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              bus_wr_i,
  input logic [ADDR_W-1:0] bus_addr_i,
  input logic [31:0]       bus_wdata_i,
  input logic              exec_o,
  input logic [3:0]        cur_q,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [31:0]       status_q
);
  assert_exec_on_write_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exec_o |-> bus_wr_i);

  assert_unknown_no_exec_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_W'(0) && (bus_wdata_i == 32'd0 || bus_wdata_i >= 32'd10))
      |-> !exec_o);

  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(ARG_WORDS));

  assert_idle_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_q == 4'd0) |-> (cnt_q == '0));

  assert_code_restarts_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bus_wr_i && bus_addr_i == ADDR_W'(0)) |=> (cnt_q == '0));

  assert_status_quiet_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bus_wr_i |=> $stable(status_q));
endmodule

bind cmd_collector cmd_collector_chk #(.ADDR_W(ADDR_W), .ARG_WORDS(ARG_WORDS)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_wr_i    (bus_wr_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .exec_o      (exec_o),
  .cur_q       (cur_q),
  .cnt_q       (cnt_q),
  .status_q    (status_q)
);

// File: tb/cmd_collector_tb_top.sv
module cmd_collector_tb_top;
  localparam int ARG_WORDS = 6;
  localparam logic [31:0] OK = 32'h0, MORE = 32'h1, FAIL_ST = 32'hFFFF_FFFF;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, exec_result = 32'hA5;
  logic exec;
  logic [3:0] exec_cmd;
  logic [ARG_WORDS*32-1:0] exec_args;

  int errs = 0, checks = 0;
  bit finished = 0;
  logic seen_ex;
  logic [3:0] seen_cmd;
  logic [ARG_WORDS*32-1:0] seen_args;

  always #10 clk = ~clk;

  cmd_collector dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bus_wr_i(bus_wr), .bus_rd_i(bus_rd),
    .bus_addr_i(bus_addr), .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
    .exec_o(exec), .exec_cmd_o(exec_cmd), .exec_args_o(exec_args),
    .exec_result_i(exec_result)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #5;
    seen_ex = exec; seen_cmd = exec_cmd; seen_args = exec_args;
    @(posedge clk); #1;
    bus_wr = 1'b0;
    #1;
    chk("R12 strobe gone after write", 32'(exec), 0);
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(posedge clk); #1;
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic status_is(string tag, logic [31:0] exp);
    logic [31:0] v;
    rd(4'h8, v);
    chk(tag, v, exp);
  endtask

  task automatic t_reset;
    status_is("R1 status after reset", OK);
    chk("R1 no strobe after reset", 32'(exec), 0);
  endtask

  task automatic t_unknown;
    logic [31:0] codes [3] = '{32'd0, 32'd10, 32'h0000_0104};
    foreach (codes[i]) begin
      wr(4'h0, codes[i]);
      chk("R2 unknown code no strobe", 32'(seen_ex), 0);
      status_is("R2 unknown code fails", FAIL_ST);
    end
  endtask

  task automatic t_pair;
    exec_result = 32'h0000_00A5;
    wr(4'h0, 32'd5);
    chk("R3 code write no strobe", 32'(seen_ex), 0);
    status_is("R3 more data needed", MORE);
    wr(4'h4, 32'h1111_0000);
    chk("R4 first word no strobe", 32'(seen_ex), 0);
    status_is("R4 still waiting", MORE);
    wr(4'h4, 32'h2222_0001);
    chk("R5 strobe on last word", 32'(seen_ex), 1);
    chk("R5 strobe code", 32'(seen_cmd), 5);
    chk("R8 word 0 position", seen_args[31:0], 32'h1111_0000);
    chk("R8 word 1 position", seen_args[63:32], 32'h2222_0001);
    status_is("R5 result latched", 32'h0000_00A5);
  endtask

  task automatic t_zero_size;
    exec_result = 32'h0000_0077;
    wr(4'h0, 32'd6);
    chk("R5 code 6 immediate strobe", 32'(seen_ex), 1);
    chk("R5 code 6 strobe code", 32'(seen_cmd), 6);
    status_is("R5 code 6 result", 32'h77);
    exec_result = 32'h0000_0033;
    wr(4'h0, 32'd8);
    chk("R5 code 8 immediate strobe", 32'(seen_ex), 1);
    status_is("R5 code 8 result", 32'h33);
  endtask

  task automatic t_local_fail;
    wr(4'h0, 32'd1);
    for (int i = 0; i < 5; i++) wr(4'h4, 32'(i));
    status_is("R6 config waits for six words", MORE);
    wr(4'h4, 32'd9);
    chk("R6 config no strobe", 32'(seen_ex), 0);
    status_is("R6 config fails", FAIL_ST);
    wr(4'h0, 32'd0); // park status at FAIL then show success path clears it
    exec_result = 32'h0;
    wr(4'h0, 32'd6);
    wr(4'h0, 32'd2);
    chk("R6 code 2 no strobe", 32'(seen_ex), 0);
    status_is("R6 code 2 fails", FAIL_ST);
    wr(4'h0, 32'd6);
    wr(4'h0, 32'd3);
    chk("R6 code 3 no strobe", 32'(seen_ex), 0);
    status_is("R6 code 3 fails", FAIL_ST);
  endtask

  task automatic ring(logic [31:0] rq, logic [31:0] cp, bit good);
    exec_result = 32'h0000_0042;
    wr(4'h0, 32'd4);
    wr(4'h4, rq);
    wr(4'h4, cp);
    wr(4'h4, 32'hDEAD_0002);
    chk("R7 ring not done before word 4", 32'(seen_ex), 0);
    wr(4'h4, 32'hBEEF_0003);
    chk("R7 ring strobe", 32'(seen_ex), 32'(good));
    status_is("R7 ring status", good ? 32'h42 : FAIL_ST);
    if (good) chk("R8 ring word 3", seen_args[127:96], 32'hBEEF_0003);
  endtask

  task automatic t_ring;
    ring(32'd3, 32'd7, 1);
    ring(32'd0, 32'd5, 0);
    ring(32'd4, 32'd0, 0);
    ring(32'd33, 32'd1, 0);
    ring(32'd32, 32'd32, 1);
  endtask

  task automatic t_idle_data;
    exec_result = 32'h0000_0011;
    wr(4'h0, 32'd6);
    wr(4'h4, 32'h1234_5678);
    chk("R9 idle data no strobe", 32'(seen_ex), 0);
    status_is("R9 idle data fails", FAIL_ST);
  endtask

  task automatic t_restart;
    exec_result = 32'h0000_0055;
    wr(4'h0, 32'd9);
    wr(4'h4, 32'hAAAA_0000);
    wr(4'h0, 32'd9);
    wr(4'h4, 32'hBBBB_0000);
    chk("R10 restart no early strobe", 32'(seen_ex), 0);
    status_is("R10 restart still waiting", MORE);
    wr(4'h4, 32'hCCCC_0000);
    chk("R10 strobe after restart", 32'(seen_ex), 1);
    chk("R10 first word is new one", seen_args[31:0], 32'hBBBB_0000);
    status_is("R10 result", 32'h55);
  endtask

  task automatic t_reads;
    logic [31:0] a, b;
    rd(4'h8, a);
    rd(4'h8, b);
    chk("R11 repeated read stable", b, a);
    rd(4'h0, a);
    chk("R11 other offset reads zero", a, 0);
    rd(4'h4, a);
    chk("R11 data offset reads zero", a, 0);
    status_is("R11 status unchanged by reads", 32'h55);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    t_reset();
    t_unknown();
    t_pair();
    t_zero_size();
    t_local_fail();
    t_ring();
    t_idle_data();
    t_restart();
    t_reads();
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errs++; checks++;
      $display("FAIL watchdog: got hang expected completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule